// File: doc/BRIEF.md
# Read-Modify-Write Bus Cycle Sequencer

This block is a bus master that performs one indivisible read-modify-write transfer on an asynchronous bus. The bus uses an address strobe, separate upper and lower data strobes, an acknowledge and a bus error. A requester inside the chip pulses a request carrying the address, the function code, the byte lanes and the value to write back. The sequencer first reads the location. It holds the address strobe low across the gap between the two halves, and then writes the new value. The read data, an error flag and a one-cycle done pulse are returned to the requester.

The bus timeline is counted in half-clock states S0 to S19. One internal clock cycle equals one state. The acknowledge and bus error inputs are active low. They pass through a two-stage synchronizer before they are sampled. The termination is sampled in S4 for the read half and in S16 for the write half. When neither input is seen, the sequencer adds wait states two cycles at a time. A read that ends in bus error drops the strobes at once and never starts the write half.

Cycle numbering in the requirements: t = 0 is the clock cycle that follows the edge at which the request is taken. The pins show state S0 during t = 0. Wr and Ww are the number of read and write wait-state pairs. A wait-state pair adds two cycles. Every state after the sampling state shifts by 2·Wr in the read half and by 2·Ww in the write half.

Top module: `rmw_seq`

## Requirements
- R1: During reset and right after it, the bus is idle. The idle levels are: bus_as_n = 1, bus_uds_n = 1, bus_lds_n = 1, bus_rw = 1, bus_doe = 0 and rsp_done = 0.
- R2: In the read half, bus_rw stays 1. The data strobes are driven low for S2 through S6, and only on the selected lanes: req_be bit 1 selects the upper strobe and bit 0 selects the lower strobe.
- R3: bus_as_n is 0 from S2 through S18 without a break when the read succeeds, and it is 1 in S19. bus_addr and bus_fc keep the value taken with the request from t = 0 until the cycle ends.
- R4: bus_rw is 0 from S14 through S19. bus_doe is 1 from S15 through S19, and it is the only time bus_dout is driven. After S19, bus_rw returns to 1 and bus_doe returns to 0.
- R5: In the write half, the selected data strobes are low for S16 through S18. bus_dout holds req_wdata the whole time bus_doe is 1.
- R6: The terminations are sampled after the two-stage synchronizer, in S4 and S16. A sample in which neither acknowledge nor bus error is seen adds one pair of wait cycles. During a wait pair, no pin changes.
- R7: If the read half sees bus error, alone or together with acknowledge, the sequencer goes on through S5 and S6. In S7 it drives bus_as_n and both data strobes high, and bus_rw never goes low. rsp_done pulses at t = 8 + 2·Wr with rsp_err = 1, and rsp_rdata keeps its previous value.
- R8: If the write half sees bus error without acknowledge, the write half still runs to the end of S19. rsp_err is then 1, and rsp_rdata holds the data that was read.
- R9: If the write half sees acknowledge, with or without bus error, the transfer ends with rsp_err = 0.
- R10: When the read succeeds, rsp_rdata takes the value of bus_din during S6. rsp_done is high for exactly one cycle, at t = 20 + 2·Wr + 2·Ww.
- R11: A request pulse while a transfer is running is ignored. It starts no second transfer, and bus_addr does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle per bus half-state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse, taken when idle |
| req_addr | input | AW | Address of the transfer |
| req_fc | input | FCW | Function code of the transfer |
| req_be | input | 2 | Lane select: bit 1 upper, bit 0 lower |
| req_wdata | input | DW | Value to write in the write half |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error status of the finished transfer |
| rsp_rdata | output | DW | Data captured by the read half |
| bus_addr | output | AW | Address lines |
| bus_fc | output | FCW | Function code lines |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | DW | Write data to the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DW | Read data from the bus |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| bus_berr_n | input | 1 | Bus error, active low, asynchronous |

## Verification
The assertions check the pin rules that must hold on every cycle:
- data strobes only appear inside the address strobe;
- address and function code are stable while the strobe is held;
- the output enable is only on during a write, and the write data is stable while it is on;
- read/write falls and rises only at the points where the strobes allow it;
- the done pulse lasts one cycle.

Only the bench scenarios can show the exact cycles of each state, the number of wait pairs that follows from a given acknowledge delay, the abort after a read error, the choice of error flag for each write termination, the returned read data, and that a request during a transfer is dropped.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [4:0] {
    ST_S0   = 5'd0,  ST_S1  = 5'd1,  ST_S2  = 5'd2,  ST_S3  = 5'd3,
    ST_S4   = 5'd4,  ST_S5  = 5'd5,  ST_S6  = 5'd6,  ST_S7  = 5'd7,
    ST_S8   = 5'd8,  ST_S9  = 5'd9,  ST_S10 = 5'd10, ST_S11 = 5'd11,
    ST_S12  = 5'd12, ST_S13 = 5'd13, ST_S14 = 5'd14, ST_S15 = 5'd15,
    ST_S16  = 5'd16, ST_S17 = 5'd17, ST_S18 = 5'd18, ST_S19 = 5'd19,
    ST_IDLE = 5'd20, ST_ABT = 5'd21
  } state_t;

  typedef struct packed {
    logic as_n;
    logic ds;
    logic rw;
    logic doe;
  } pin_t;

  // Bus pin levels that belong to each half-state
  function automatic pin_t pin_decode(state_t s);
    pin_t p;
    p.as_n = 1'b1;
    p.ds   = 1'b0;
    p.rw   = 1'b1;
    p.doe  = 1'b0;
    case (s)
      ST_S2, ST_S3, ST_S4, ST_S5, ST_S6: begin
        p.as_n = 1'b0;
        p.ds   = 1'b1;
      end
      ST_S7, ST_S8, ST_S9, ST_S10, ST_S11, ST_S12, ST_S13: p.as_n = 1'b0;
      ST_S14: begin
        p.as_n = 1'b0;
        p.rw   = 1'b0;
      end
      ST_S15: begin
        p.as_n = 1'b0;
        p.rw   = 1'b0;
        p.doe  = 1'b1;
      end
      ST_S16, ST_S17, ST_S18: begin
        p.as_n = 1'b0;
        p.ds   = 1'b1;
        p.rw   = 1'b0;
        p.doe  = 1'b1;
      end
      ST_S19: begin
        p.rw  = 1'b0;
        p.doe = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rmw_sync.sv
module rmw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   ack_s,
  input  logic   berr_s,
  output state_t state_d,
  output logic   accept,
  output logic   rd_latch,
  output logic   done,
  output logic   err
);

  state_t state_q;
  logic   wt_q, wt_d;
  logic   abt_q, abt_d;
  logic   werr_q, werr_d;
  logic   fin;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign rd_latch = (state_q == ST_S6) && !abt_q;
  assign fin      = (state_q == ST_S19) || (state_q == ST_ABT);

  always_comb begin
    state_d = state_q;
    wt_d    = wt_q;
    abt_d   = abt_q;
    werr_d  = werr_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_S0;
          abt_d   = 1'b0;
          werr_d  = 1'b0;
          wt_d    = 1'b0;
        end
      end
      ST_S4: begin
        if (wt_q)                wt_d = 1'b0;
        else if (ack_s || berr_s) begin
          state_d = ST_S5;
          abt_d   = berr_s;
        end else                 wt_d = 1'b1;
      end
      ST_S6:  state_d = abt_q ? ST_ABT : ST_S7;
      ST_ABT: state_d = ST_IDLE;
      ST_S16: begin
        if (wt_q)       wt_d = 1'b0;
        else if (ack_s) state_d = ST_S17;
        else if (berr_s) begin
          state_d = ST_S17;
          werr_d  = 1'b1;
        end else        wt_d = 1'b1;
      end
      ST_S19: state_d = ST_IDLE;
      default: state_d = state_t'(state_q + 5'd1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wt_q    <= 1'b0;
      abt_q   <= 1'b0;
      werr_q  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      wt_q    <= wt_d;
      abt_q   <= abt_d;
      werr_q  <= werr_d;
      done    <= fin;
      if (fin) err <= abt_q || werr_q;
    end
  end

endmodule

// File: rtl/rmw_dpath.sv
module rmw_dpath
  import rmw_pkg::*;
#(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int FCW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  state_t         state_d,
  input  logic           accept,
  input  logic           rd_latch,
  input  logic [AW-1:0]  req_addr,
  input  logic [FCW-1:0] req_fc,
  input  logic [1:0]     req_be,
  input  logic [DW-1:0]  req_wdata,
  input  logic [DW-1:0]  bus_din,
  output logic [DW-1:0]  rsp_rdata,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic           bus_as_n,
  output logic           bus_uds_n,
  output logic           bus_lds_n,
  output logic           bus_rw,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_doe
);

  logic [1:0] be_q;
  logic [1:0] be_use;
  pin_t       pv;

  assign pv     = pin_decode(state_d);
  assign be_use = accept ? req_be : be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      be_q      <= '0;
      bus_addr  <= '0;
      bus_fc    <= '0;
      bus_dout  <= '0;
      rsp_rdata <= '0;
      bus_as_n  <= 1'b1;
      bus_uds_n <= 1'b1;
      bus_lds_n <= 1'b1;
      bus_rw    <= 1'b1;
      bus_doe   <= 1'b0;
    end else begin
      if (accept) begin
        be_q     <= req_be;
        bus_addr <= req_addr;
        bus_fc   <= req_fc;
        bus_dout <= req_wdata;
      end
      if (rd_latch) rsp_rdata <= bus_din;
      bus_as_n  <= pv.as_n;
      bus_uds_n <= !(pv.ds && be_use[1]);
      bus_lds_n <= !(pv.ds && be_use[0]);
      bus_rw    <= pv.rw;
      bus_doe   <= pv.doe;
    end
  end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int FCW         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [FCW-1:0] req_fc,
  input  logic [1:0]     req_be,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_done,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic           bus_as_n,
  output logic           bus_uds_n,
  output logic           bus_lds_n,
  output logic           bus_rw,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_doe,
  input  logic [DW-1:0]  bus_din,
  input  logic           bus_dtack_n,
  input  logic           bus_berr_n
);

  logic [1:0] term_s;
  state_t     state_d;
  logic       accept;
  logic       rd_latch;

  rmw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({~bus_berr_n, ~bus_dtack_n}),
    .q   (term_s)
  );

  rmw_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ack_s     (term_s[0]),
    .berr_s    (term_s[1]),
    .state_d   (state_d),
    .accept    (accept),
    .rd_latch  (rd_latch),
    .done      (rsp_done),
    .err       (rsp_err)
  );

  rmw_dpath #(.AW(AW), .DW(DW), .FCW(FCW)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .accept    (accept),
    .rd_latch  (rd_latch),
    .req_addr  (req_addr),
    .req_fc    (req_fc),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .bus_din   (bus_din),
    .rsp_rdata (rsp_rdata),
    .bus_addr  (bus_addr),
    .bus_fc    (bus_fc),
    .bus_as_n  (bus_as_n),
    .bus_uds_n (bus_uds_n),
    .bus_lds_n (bus_lds_n),
    .bus_rw    (bus_rw),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe)
  );

endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int FCW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           rsp_done,
  input logic [AW-1:0]  bus_addr,
  input logic [FCW-1:0] bus_fc,
  input logic           bus_as_n,
  input logic           bus_uds_n,
  input logic           bus_lds_n,
  input logic           bus_rw,
  input logic [DW-1:0]  bus_dout,
  input logic           bus_doe
);

  p_ds_inside_as_r2: assert property (@(posedge clk) disable iff (rst)
    (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_fc)));

  p_rw_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rw) |-> (!bus_as_n && bus_uds_n && bus_lds_n && !bus_doe));

  p_rw_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rw) |-> (bus_as_n && !bus_doe));

  p_doe_write_r4: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> !bus_rw);

  p_dout_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_doe && $past(bus_doe)) |-> $stable(bus_dout));

  p_wr_ds_doe_r5: assert property (@(posedge clk) disable iff (rst)
    (!bus_rw && (!bus_uds_n || !bus_lds_n)) |-> bus_doe);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

bind rmw_seq rmw_seq_chk #(.AW(AW), .DW(DW), .FCW(FCW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rsp_done  (rsp_done),
  .bus_addr  (bus_addr),
  .bus_fc    (bus_fc),
  .bus_as_n  (bus_as_n),
  .bus_uds_n (bus_uds_n),
  .bus_lds_n (bus_lds_n),
  .bus_rw    (bus_rw),
  .bus_dout  (bus_dout),
  .bus_doe   (bus_doe)
);

// File: tb/rmw_seq_test.sv
`timescale 1ns/100ps
module rmw_seq_test;

  localparam int AW = 24, DW = 16, FCW = 3, NREC = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [FCW-1:0] req_fc = '0;
  logic [1:0] req_be = 2'b11;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic bus_dtack_n = 1'b1, bus_berr_n = 1'b1;
  logic rsp_done, rsp_err, bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe;
  logic [DW-1:0] rsp_rdata, bus_dout;
  logic [AW-1:0] bus_addr;
  logic [FCW-1:0] bus_fc;

  int nchk = 0, nfail = 0;
  int rd_dly = 0, rd_mode = 0, wr_dly = 0, wr_mode = 0, ds_cnt = 0;
  logic [DW-1:0] last_rd = '0;

  always #2.5 clk = ~clk;

  rmw_seq #(.AW(AW), .DW(DW), .FCW(FCW)) uut (.*);

  // Slave model: mode 0 = acknowledge, 1 = bus error, 2 = both
  always @(negedge clk) begin
    if (rst || (bus_uds_n && bus_lds_n)) begin
      bus_dtack_n = 1'b1;
      bus_berr_n  = 1'b1;
      ds_cnt      = 0;
    end else begin
      if (ds_cnt >= (bus_rw ? rd_dly : wr_dly)) begin
        bus_dtack_n = ((bus_rw ? rd_mode : wr_mode) == 1);
        bus_berr_n  = ((bus_rw ? rd_mode : wr_mode) == 0);
      end
      ds_cnt = ds_cnt + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected state per cycle: -1 idle, 107 = aborting S7
  function automatic int exp_st(int t, int wr, int ww, bit abt);
    int s;
    if (t <= 4) return t;
    if (t <= 4 + 2*wr) return 4;
    s = t - 2*wr;
    if (abt) return (s < 7) ? s : ((s == 7) ? 107 : -1);
    if (s < 16) return s;
    if (s <= 16 + 2*ww) return 16;
    s = s - 2*ww;
    return (s <= 19) ? s : -1;
  endfunction

  task automatic run_rmw(string req, logic [1:0] be, int rdly, int rmode,
                         int wdly, int wmode, int xreq);
    int wr, ww, tend, st, ndone, tdone;
    bit abt, as_ok, ds_ok, rw_ok, doe_ok, ad_ok, do_ok, err_e, e_as, e_ds, e_rw, e_doe;
    logic [AW-1:0] a;
    logic [FCW-1:0] f;
    logic [DW-1:0] wd, din, rd_e, rd_at;
    bit err_at;
    a = 24'h5A0000 + AW'(rdly * 16 + wdly);
    f = 3'(rmode + 2*wmode + 1);
    wd = 16'hC3A0 ^ DW'(xreq);
    din = 16'h1E00 + DW'(rdly + rmode);
    rd_dly = rdly; rd_mode = rmode; wr_dly = wdly; wr_mode = wmode;
    abt = (rmode != 0);
    wr = (rdly + 1) / 2;
    ww = 1 + (wdly + 1) / 2;
    tend = abt ? 8 + 2*wr : 20 + 2*wr + 2*ww;
    err_e = abt || (wmode == 1);
    rd_e = abt ? last_rd : din;
    as_ok = 1; ds_ok = 1; rw_ok = 1; doe_ok = 1; ad_ok = 1; do_ok = 1;
    ndone = 0; tdone = -1; rd_at = '0; err_at = 0;
    bus_din = din;
    @(negedge clk);
    req_addr = a; req_fc = f; req_be = be; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < NREC; t++) begin
      st = exp_st(t, wr, ww, abt);
      e_as  = !(st >= 2 && st <= 18 && st != 107);
      e_ds  = (st >= 2 && st <= 6) || (st >= 16 && st <= 18);
      e_rw  = !(st >= 14 && st <= 19);
      e_doe = (st >= 15 && st <= 19);
      if (bus_as_n !== e_as) as_ok = 0;
      if (bus_uds_n !== !(e_ds && be[1]) || bus_lds_n !== !(e_ds && be[0])) ds_ok = 0;
      if (bus_rw !== e_rw) rw_ok = 0;
      if (bus_doe !== e_doe) doe_ok = 0;
      if (t < tend && (bus_addr !== a || bus_fc !== f)) ad_ok = 0;
      if (bus_doe && bus_dout !== wd) do_ok = 0;
      if (rsp_done) begin
        ndone++;
        if (tdone < 0) begin tdone = t; rd_at = rsp_rdata; err_at = rsp_err; end
      end
      if (t == xreq) begin req_addr = ~a; req_valid = 1'b1; end
      if (t == xreq + 1) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(as_ok,  {"R3/", req}, "address strobe timing", bus_as_n, e_as);
    chk(ds_ok,  {"R2/R5/", req}, "data strobe timing", {bus_uds_n, bus_lds_n}, be);
    chk(rw_ok,  {"R4/", req}, "read/write timing", bus_rw, e_rw);
    chk(doe_ok, {"R4/", req}, "output enable timing", bus_doe, e_doe);
    chk(ad_ok,  {"R3/", req}, "address/fc hold", bus_addr, a);
    chk(do_ok,  {"R5/", req}, "write data", bus_dout, wd);
    chk(tdone == tend && ndone == 1, {"R10/", req}, "done cycle", tdone, tend);
    chk(err_at == err_e, {"R7/R8/R9/", req}, "error flag", err_at, err_e);
    chk(rd_at == rd_e, {"R10/", req}, "read data", rd_at, rd_e);
    if (!abt) last_rd = din;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(bus_as_n && bus_uds_n && bus_lds_n && bus_rw && !bus_doe && !rsp_done,
        "R1", "pins in reset", {bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe, rsp_done}, 6'b111100);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_as_n && bus_uds_n && bus_lds_n && bus_rw && !bus_doe && !rsp_done,
        "R1", "pins after reset", {bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe, rsp_done}, 6'b111100);
  endtask

  task automatic t_basic;       run_rmw("R2 basic", 2'b11, 0, 0, 0, 0, -9); endtask
  task automatic t_waits;       run_rmw("R6 waits", 2'b01, 3, 0, 2, 0, -9); endtask
  task automatic t_rd_berr;     run_rmw("R7 read berr", 2'b10, 1, 1, 0, 0, -9); endtask
  task automatic t_rd_both;     run_rmw("R7 read both", 2'b11, 0, 2, 0, 0, -9); endtask
  task automatic t_wr_berr;     run_rmw("R8 write berr", 2'b11, 0, 0, 1, 1, -9); endtask
  task automatic t_wr_both;     run_rmw("R9 write both", 2'b10, 2, 0, 0, 2, -9); endtask
  task automatic t_busy_req;    run_rmw("R11 busy request", 2'b11, 0, 0, 0, 0, 5); endtask

  initial begin
    t_reset();
    t_basic();
    t_waits();
    t_rd_berr();
    t_rd_both();
    t_wr_berr();
    t_wr_both();
    t_busy_req();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule